// File: doc/BRIEF.md
# UART Host Register Front End

This block is the word-addressed register window that a processor uses to run a simple serial port. Through it the host pushes bytes toward a transmit FIFO, pops bytes from a receive FIFO, sets parity, break and port enable, loads the baud divider fields and handles two interrupt sources. The serializer, the baud generator and the FIFOs sit outside the block. Each of them is seen through a plain level or single-cycle handshake: a valid/pop pair on the receive side, a ready/push pair on the transmit side, and an idle level from the serializer.

Bus reads are combinational and have no side effects. All byte movement is requested by writes to the data word, and each request is qualified by a handshake bit carried in that same write. A byte leaves the receive FIFO only when the write has the receive-valid bit set. A byte enters the transmit FIFO only when the write has the transmit-strobe bit set. Interrupt status is sticky and is cleared by writing ones. The output line is the masked summary, gated by a host-level enable.

Top module: `uart_host_regs`

## Requirements
- R1: After reset every register reads zero and all configuration outputs are low. The control word at offset 0x04 reads back the written bits: [1:0] parity code, [3:2] interface mode, [4] transmit-ready override, [5] receive-ready override, [6] break, [7] host interrupt enable.
- R2: A read of the data word at offset 0x00 returns bit 8 = receive byte available and bit 9 = transmitter can accept a byte. Bits [7:0] hold the received byte while one is available and are zero otherwise.
- R3: A write to offset 0x00 with bit 8 set pulses `rx_fifo_pop` in that same cycle, but only while `rx_fifo_valid` is high. Every other write leaves the receive FIFO alone.
- R4: A write to offset 0x00 with bit 9 set pulses `tx_fifo_push` in that cycle, with `tx_fifo_data` equal to bits [7:0]. This happens only while `tx_fifo_ready` is high and the interface mode is non-zero. A write without bit 9, a write while not ready, and a write while the mode is zero push nothing.
- R5: Interrupt status at offset 0x0C has bit 0 for receive-valid and bit 1 for transmit-empty. Each bit is set on the clock edge after its source is seen high, stays set, and is cleared by writing 1 to it. A source that is still high in the clearing cycle keeps its bit set.
- R6: Control bit 8 is a read-only summary that is high when any status bit and its enable bit at offset 0x10 (bit 0 receive, bit 1 transmit) are both set. The `irq` output equals that summary ANDed with control bit 7.
- R7: The clock word at offset 0x08 stores step in bits [15:0] and scale in bits [23:16]. Bits [31:24] read zero. Both fields drive `cfg_step` and `cfg_scale`.
- R8: Parity code 00 means none, 01 even, 10 odd, and 11 is treated as none. `cfg_break` follows control bit 6, and `cfg_port_en` is high whenever the mode field is non-zero.
- R9: A read of any unmapped word (offset 0x14 and above) returns zero, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_fifo_valid | input | 1 | Receive FIFO holds a byte |
| rx_fifo_data | input | DATA_W | Head byte of the receive FIFO |
| rx_fifo_pop | output | 1 | Remove the head byte |
| tx_fifo_ready | input | 1 | Transmit FIFO can accept a byte |
| tx_fifo_push | output | 1 | Push `tx_fifo_data` |
| tx_fifo_data | output | DATA_W | Byte to transmit |
| tx_empty | input | 1 | Serializer and transmit FIFO idle |
| cfg_port_en | output | 1 | Port enabled (mode non-zero) |
| cfg_par_en | output | 1 | Parity bit generated and checked |
| cfg_par_odd | output | 1 | Odd parity when enabled |
| cfg_break | output | 1 | Hold the line in break |
| cfg_tx_rdy_ovr | output | 1 | Transmit-ready override |
| cfg_rx_rdy_ovr | output | 1 | Receive-ready override |
| cfg_scale | output | SCALE_W | Baud prescale field |
| cfg_step | output | STEP_W | Baud step field |
| irq | output | 1 | Host interrupt line |

## Verification
The bench builds the block with its defaults: a 5-bit address, 8-bit characters, an 8-bit scale and a 16-bit step. With these values the handshake bits sit at 8 and 9 and the clock fields fill bits [23:0], so every field boundary named in the requirements can be observed at the ports. The 5-bit address also reaches the first unmapped word at 0x14. Two interrupt sources are enough to drive the set-wins-over-clear race, and to show the host enable masking the line while the summary bit stays high.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

   // word indices of the register window (byte offset / 4)
   localparam int unsigned WORD_DATA = 0;
   localparam int unsigned WORD_CTRL = 1;
   localparam int unsigned WORD_CLK  = 2;
   localparam int unsigned WORD_ISR  = 3;
   localparam int unsigned WORD_IER  = 4;

   // control word bit positions
   localparam int unsigned CTL_PAR_LO  = 0;
   localparam int unsigned CTL_MODE_LO = 2;
   localparam int unsigned CTL_TXOVR   = 4;
   localparam int unsigned CTL_RXOVR   = 5;
   localparam int unsigned CTL_BRK     = 6;
   localparam int unsigned CTL_HIEN    = 7;
   localparam int unsigned CTL_W       = 8;
   localparam int unsigned CTL_SUMMARY = 8;

   // interrupt sources
   localparam int unsigned NUM_IRQ = 2;
   localparam int unsigned IRQ_RX  = 0;
   localparam int unsigned IRQ_TX  = 1;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_CTRL,
      SEL_CLK,
      SEL_ISR,
      SEL_IER
   } reg_sel_e;

   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_EVEN = 2'b01,
      PAR_ODD  = 2'b10,
      PAR_RSVD = 2'b11
   } par_code_e;

   typedef struct packed {
      logic en;
      logic odd;
   } par_cfg_t;

   function automatic par_cfg_t decode_parity(input logic [1:0] code);
      par_cfg_t p;
      unique case (par_code_e'(code))
         PAR_EVEN: p = '{en: 1'b1, odd: 1'b0};
         PAR_ODD:  p = '{en: 1'b1, odd: 1'b1};
         default:  p = '{en: 1'b0, odd: 1'b0};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/uart_regif_decode.sv
module uart_regif_decode
   import uart_regif_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          which
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             unused_byte_lanes;

   assign idx               = addr[ADDR_W-1:2];
   assign unused_byte_lanes = ^addr[1:0];

   always_comb begin
      which = SEL_NONE;
      if (sel) begin
         case (idx)
            IDX_W'(WORD_DATA): which = SEL_DATA;
            IDX_W'(WORD_CTRL): which = SEL_CTRL;
            IDX_W'(WORD_CLK):  which = SEL_CLK;
            IDX_W'(WORD_ISR):  which = SEL_ISR;
            IDX_W'(WORD_IER):  which = SEL_IER;
            default:           which = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/uart_regif_data.sv
module uart_regif_data #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              wr_strobe,
   input  logic [31:0]       wdata,
   input  logic              port_en,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              tx_ready,
   output logic              rx_pop,
   output logic              tx_push,
   output logic [DATA_W-1:0] tx_data,
   output logic [31:0]       rd_word
);

   localparam int unsigned RXV_BIT = DATA_W;
   localparam int unsigned TXS_BIT = DATA_W + 1;

   assign rx_pop  = wr_strobe & wdata[RXV_BIT] & rx_valid;
   assign tx_push = wr_strobe & wdata[TXS_BIT] & tx_ready & port_en;
   assign tx_data = wdata[DATA_W-1:0];

   always_comb begin
      rd_word                = '0;
      rd_word[DATA_W-1:0]    = rx_valid ? rx_data : '0;
      rd_word[RXV_BIT]       = rx_valid;
      rd_word[TXS_BIT]       = tx_ready;
   end

endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq #(
   parameter int unsigned NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] clr_mask,
   input  logic [NUM_SRC-1:0] ena,
   output logic [NUM_SRC-1:0] status,
   output logic               pend
);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            status[g] <= 1'b0;
         end else if (src[g]) begin
            status[g] <= 1'b1;
         end else if (clr_we && clr_mask[g]) begin
            status[g] <= 1'b0;
         end
      end
   end

   assign pend = |(status & ena);

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
   import uart_regif_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned SCALE_W = 8,
   parameter int unsigned STEP_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic               rx_fifo_valid,
   input  logic [DATA_W-1:0]  rx_fifo_data,
   output logic               rx_fifo_pop,
   input  logic               tx_fifo_ready,
   output logic               tx_fifo_push,
   output logic [DATA_W-1:0]  tx_fifo_data,
   input  logic               tx_empty,
   output logic               cfg_port_en,
   output logic               cfg_par_en,
   output logic               cfg_par_odd,
   output logic               cfg_break,
   output logic               cfg_tx_rdy_ovr,
   output logic               cfg_rx_rdy_ovr,
   output logic [SCALE_W-1:0] cfg_scale,
   output logic [STEP_W-1:0]  cfg_step,
   output logic               irq
);

   localparam int unsigned CLK_FIELDS_W = SCALE_W + STEP_W;

   // elaboration-time parameter checks
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("ADDR_W must cover five words");
   end
   if (DATA_W < 5 || DATA_W > 30) begin : g_bad_data_w
      $error("DATA_W plus two handshake bits must fit a word");
   end
   if (CLK_FIELDS_W > 32 || SCALE_W == 0 || STEP_W == 0) begin : g_bad_clk_w
      $error("clock fields must fit one word");
   end

   reg_sel_e            which;
   logic                wr_en;
   logic [CTL_W-1:0]    ctrl_q;
   logic [SCALE_W-1:0]  scale_q;
   logic [STEP_W-1:0]   step_q;
   logic [NUM_IRQ-1:0]  ier_q;
   logic [NUM_IRQ-1:0]  isr_q;
   logic [NUM_IRQ-1:0]  irq_src;
   logic                irq_pend;
   logic                host_en;
   logic [31:0]         data_rd;
   logic [31:0]         clk_rd;
   logic                isr_wr;
   logic                ctrl_wr;
   par_cfg_t            par;

   uart_regif_decode #(.ADDR_W(ADDR_W)) i_decode (
      .sel   (bus_sel),
      .addr  (bus_addr),
      .which (which)
   );

   assign wr_en   = bus_sel & bus_wr;
   assign ctrl_wr = wr_en && (which == SEL_CTRL);
   assign isr_wr  = wr_en && (which == SEL_ISR);

   uart_regif_data #(.DATA_W(DATA_W)) i_data (
      .wr_strobe (wr_en && (which == SEL_DATA)),
      .wdata     (bus_wdata),
      .port_en   (cfg_port_en),
      .rx_valid  (rx_fifo_valid),
      .rx_data   (rx_fifo_data),
      .tx_ready  (tx_fifo_ready),
      .rx_pop    (rx_fifo_pop),
      .tx_push   (tx_fifo_push),
      .tx_data   (tx_fifo_data),
      .rd_word   (data_rd)
   );

   // control word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= bus_wdata[CTL_W-1:0];
      end
   end

   // baud divider fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scale_q <= '0;
         step_q  <= '0;
      end else if (wr_en && (which == SEL_CLK)) begin
         step_q  <= bus_wdata[STEP_W-1:0];
         scale_q <= bus_wdata[CLK_FIELDS_W-1:STEP_W];
      end
   end

   // interrupt enables
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q <= '0;
      end else if (wr_en && (which == SEL_IER)) begin
         ier_q <= bus_wdata[NUM_IRQ-1:0];
      end
   end

   // sticky interrupt status
   always_comb begin
      irq_src         = '0;
      irq_src[IRQ_RX] = rx_fifo_valid;
      irq_src[IRQ_TX] = tx_empty;
   end

   uart_regif_irq #(.NUM_SRC(NUM_IRQ)) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (irq_src),
      .clr_we   (isr_wr),
      .clr_mask (bus_wdata[NUM_IRQ-1:0]),
      .ena      (ier_q),
      .status   (isr_q),
      .pend     (irq_pend)
   );

   // configuration outputs
   assign par            = decode_parity(ctrl_q[CTL_PAR_LO +: 2]);
   assign cfg_par_en     = par.en;
   assign cfg_par_odd    = par.odd;
   assign cfg_port_en    = |ctrl_q[CTL_MODE_LO +: 2];
   assign cfg_break      = ctrl_q[CTL_BRK];
   assign cfg_tx_rdy_ovr = ctrl_q[CTL_TXOVR];
   assign cfg_rx_rdy_ovr = ctrl_q[CTL_RXOVR];
   assign cfg_scale      = scale_q;
   assign cfg_step       = step_q;
   assign host_en        = ctrl_q[CTL_HIEN];
   assign irq            = host_en & irq_pend;

   always_comb begin
      clk_rd                           = '0;
      clk_rd[STEP_W-1:0]               = step_q;
      clk_rd[CLK_FIELDS_W-1:STEP_W]    = scale_q;
   end

   // read mux, no side effects
   always_comb begin
      bus_rdata = '0;
      case (which)
         SEL_DATA: bus_rdata = data_rd;
         SEL_CTRL: begin
            bus_rdata[CTL_W-1:0]  = ctrl_q;
            bus_rdata[CTL_SUMMARY] = irq_pend;
         end
         SEL_CLK:  bus_rdata = clk_rd;
         SEL_ISR:  bus_rdata[NUM_IRQ-1:0] = isr_q;
         SEL_IER:  bus_rdata[NUM_IRQ-1:0] = ier_q;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk #(
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              rx_fifo_valid,
   input logic              rx_fifo_pop,
   input logic              tx_fifo_ready,
   input logic              tx_fifo_push,
   input logic              cfg_port_en,
   input logic              cfg_break,
   input logic              tx_empty,
   input logic              irq,
   input logic              host_en,
   input logic [1:0]        isr_q
);

   logic isr_access;
   logic ctl_access;

   assign isr_access = bus_sel && bus_wr && ((bus_addr >> 2) == ADDR_W'(3));
   assign ctl_access = bus_sel && bus_wr && ((bus_addr >> 2) == ADDR_W'(1));

   // R3: no pop of an empty receive FIFO
   a_r3_pop_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fifo_pop |-> rx_fifo_valid);

   // R4: push only into a ready FIFO on an enabled port
   a_r4_push_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fifo_push |-> (tx_fifo_ready && cfg_port_en));

   // R5: an active source leaves its status bit set the next cycle
   a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(tx_empty)) |-> isr_q[1]);

   // R5: a status bit falls only after a clearing write
   a_r5_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $fell(isr_q[0])) |-> $past(isr_access && bus_wdata[0]));

   // R6: the line is masked by the host enable
   a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> host_en);

   // R8: break changes only through a control write
   a_r8_break_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$stable(cfg_break)) |-> $past(ctl_access));

endmodule

bind uart_host_regs uart_host_regs_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_sel       (bus_sel),
   .bus_wr        (bus_wr),
   .bus_addr      (bus_addr),
   .bus_wdata     (bus_wdata),
   .rx_fifo_valid (rx_fifo_valid),
   .rx_fifo_pop   (rx_fifo_pop),
   .tx_fifo_ready (tx_fifo_ready),
   .tx_fifo_push  (tx_fifo_push),
   .cfg_port_en   (cfg_port_en),
   .cfg_break     (cfg_break),
   .tx_empty      (tx_empty),
   .irq           (irq),
   .host_en       (host_en),
   .isr_q         (isr_q)
);

// File: tb/test_uart_host_regs.sv
module test_uart_host_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_fifo_valid = 1'b0;
   logic [7:0]  rx_fifo_data = '0;
   logic        rx_fifo_pop;
   logic        tx_fifo_ready = 1'b0;
   logic        tx_fifo_push;
   logic [7:0]  tx_fifo_data;
   logic        tx_empty = 1'b0;
   logic        cfg_port_en, cfg_par_en, cfg_par_odd, cfg_break;
   logic        cfg_tx_rdy_ovr, cfg_rx_rdy_ovr;
   logic [7:0]  cfg_scale;
   logic [15:0] cfg_step;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   uart_host_regs i_uart_host_regs (.*);

   typedef struct packed {
      logic [4:0]  addr;
      logic        wr;
      logic [31:0] wd;
      logic        rxv;
      logic [7:0]  rxd;
      logic        txr;
      logic        txe;
      logic [31:0] erd;
      logic        epop;
      logic        epush;
      logic [7:0]  etxd;
      logic        eirq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 34;
   localparam vec_t VECS [NV] = '{
      // addr   wr    wdata          rxv  rxd    txr  txe  exp rdata     pop  push txd    irq  req
      '{5'h04, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd1}, // R1 reset
      '{5'h04, 1'b1, 32'h00000085, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd1},
      '{5'h04, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000085, 1'b0, 1'b0, 8'h00, 1'b0, 4'd1}, // R1 readback
      '{5'h08, 1'b1, 32'hFF123456, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd7},
      '{5'h08, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00123456, 1'b0, 1'b0, 8'h00, 1'b0, 4'd7}, // R7
      '{5'h00, 1'b0, 32'h00000000, 1'b1, 8'h5A, 1'b1, 1'b0, 32'h0000035A, 1'b0, 1'b0, 8'h00, 1'b0, 4'd2}, // R2
      '{5'h00, 1'b1, 32'h00000100, 1'b1, 8'h5A, 1'b0, 1'b0, 32'h0000015A, 1'b1, 1'b0, 8'h00, 1'b0, 4'd3}, // R3 pop
      '{5'h10, 1'b1, 32'h00000001, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd6},
      '{5'h0C, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000001, 1'b0, 1'b0, 8'h00, 1'b1, 4'd5}, // R5 sticky
      '{5'h04, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000185, 1'b0, 1'b0, 8'h00, 1'b1, 4'd6}, // R6 summary
      '{5'h0C, 1'b1, 32'h00000001, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000001, 1'b0, 1'b0, 8'h00, 1'b1, 4'd5},
      '{5'h0C, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5}, // R5 cleared
      '{5'h00, 1'b1, 32'h000002A5, 1'b0, 8'h00, 1'b1, 1'b0, 32'h00000200, 1'b0, 1'b1, 8'hA5, 1'b0, 4'd4}, // R4 push
      '{5'h00, 1'b1, 32'h000000A5, 1'b0, 8'h00, 1'b1, 1'b0, 32'h00000200, 1'b0, 1'b0, 8'h00, 1'b0, 4'd4}, // R4 no strobe
      '{5'h00, 1'b1, 32'h000002A5, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd4}, // R4 not ready
      '{5'h00, 1'b1, 32'h00000100, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd3}, // R3 empty
      '{5'h0C, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b1, 32'h00000000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5},
      '{5'h0C, 1'b1, 32'h00000002, 1'b0, 8'h00, 1'b0, 1'b1, 32'h00000002, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5},
      '{5'h0C, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000002, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5}, // R5 set wins
      '{5'h0C, 1'b1, 32'h00000002, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000002, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5},
      '{5'h0C, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd5},
      '{5'h10, 1'b1, 32'h00000003, 1'b0, 8'h00, 1'b0, 1'b1, 32'h00000001, 1'b0, 1'b0, 8'h00, 1'b0, 4'd6},
      '{5'h0C, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000002, 1'b0, 1'b0, 8'h00, 1'b1, 4'd6},
      '{5'h04, 1'b1, 32'h00000005, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000185, 1'b0, 1'b0, 8'h00, 1'b1, 4'd6},
      '{5'h04, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000105, 1'b0, 1'b0, 8'h00, 1'b0, 4'd6}, // R6 host mask
      '{5'h04, 1'b1, 32'h00000045, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000105, 1'b0, 1'b0, 8'h00, 1'b0, 4'd8},
      '{5'h04, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000145, 1'b0, 1'b0, 8'h00, 1'b0, 4'd8}, // R8 break
      '{5'h04, 1'b1, 32'h00000041, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000145, 1'b0, 1'b0, 8'h00, 1'b0, 4'd4},
      '{5'h00, 1'b1, 32'h000002A5, 1'b0, 8'h00, 1'b1, 1'b0, 32'h00000200, 1'b0, 1'b0, 8'h00, 1'b0, 4'd4}, // R4 mode zero
      '{5'h14, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd9}, // R9 read
      '{5'h14, 1'b1, 32'hFFFFFFFF, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'h00, 1'b0, 4'd9},
      '{5'h04, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000141, 1'b0, 1'b0, 8'h00, 1'b0, 4'd9}, // R9 write
      '{5'h10, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00000003, 1'b0, 1'b0, 8'h00, 1'b0, 4'd9},
      '{5'h08, 1'b0, 32'h00000000, 1'b0, 8'h00, 1'b0, 1'b0, 32'h00123456, 1'b0, 1'b0, 8'h00, 1'b0, 4'd9}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bus_cycle(input logic [4:0] a, input logic w, input logic [31:0] d);
      @(negedge clk);
      bus_sel   = 1'b1;
      bus_wr    = w;
      bus_addr  = a;
      bus_wdata = d;
   endtask

   task automatic read_check(input logic [4:0] a, input logic [31:0] exp, input string req);
      bus_cycle(a, 1'b0, 32'h0);
      #2;
      check(bus_rdata === exp, req, "rdata", bus_rdata, exp);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      string rq;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         bus_sel       = 1'b1;
         bus_wr        = VECS[i].wr;
         bus_addr      = VECS[i].addr;
         bus_wdata     = VECS[i].wd;
         rx_fifo_valid = VECS[i].rxv;
         rx_fifo_data  = VECS[i].rxd;
         tx_fifo_ready = VECS[i].txr;
         tx_empty      = VECS[i].txe;
         #2;
         rq = $sformatf("R%0d vec%0d", VECS[i].req, i);
         check(bus_rdata === VECS[i].erd, rq, "rdata", bus_rdata, VECS[i].erd);
         check(rx_fifo_pop === VECS[i].epop, rq, "pop", 32'(rx_fifo_pop), 32'(VECS[i].epop));
         check(tx_fifo_push === VECS[i].epush, rq, "push", 32'(tx_fifo_push), 32'(VECS[i].epush));
         if (VECS[i].epush)
            check(tx_fifo_data === VECS[i].etxd, rq, "txdata", 32'(tx_fifo_data), 32'(VECS[i].etxd));
         check(irq === VECS[i].eirq, rq, "irq", 32'(irq), 32'(VECS[i].eirq));
      end

      // control now 0x41: break on, mode zero, even parity
      @(negedge clk);
      bus_sel = 1'b0;
      tx_fifo_ready = 1'b0;
      #2;
      check(cfg_break === 1'b1, "R8", "break", 32'(cfg_break), 32'h1);
      check(cfg_port_en === 1'b0, "R8", "port_en", 32'(cfg_port_en), 32'h0);
      check({cfg_par_en, cfg_par_odd} === 2'b10, "R8", "even parity",
            32'({cfg_par_en, cfg_par_odd}), 32'h2);
      check({cfg_scale, cfg_step} === 24'h123456, "R7", "clock fields",
            32'({cfg_scale, cfg_step}), 32'h123456);

      // odd parity, mode 01, overrides set
      bus_cycle(5'h04, 1'b1, 32'h00000036);
      @(negedge clk);
      bus_sel = 1'b0;
      #2;
      check({cfg_par_en, cfg_par_odd} === 2'b11, "R8", "odd parity",
            32'({cfg_par_en, cfg_par_odd}), 32'h3);
      check(cfg_port_en === 1'b1, "R8", "port_en mode01", 32'(cfg_port_en), 32'h1);
      check(cfg_break === 1'b0, "R8", "break off", 32'(cfg_break), 32'h0);
      check({cfg_tx_rdy_ovr, cfg_rx_rdy_ovr} === 2'b11, "R1", "overrides",
            32'({cfg_tx_rdy_ovr, cfg_rx_rdy_ovr}), 32'h3);

      // reserved parity code, mode 11
      bus_cycle(5'h04, 1'b1, 32'h0000000F);
      @(negedge clk);
      bus_sel = 1'b0;
      #2;
      check(cfg_par_en === 1'b0, "R8", "code 11 no parity", 32'(cfg_par_en), 32'h0);
      check(cfg_port_en === 1'b1, "R8", "port_en mode11", 32'(cfg_port_en), 32'h1);

      // mid-run reset
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check(irq === 1'b0, "R1", "irq in reset", 32'(irq), 32'h0);
      check({cfg_scale, cfg_step, cfg_port_en, cfg_break} === '0, "R1", "cfg in reset",
            32'({cfg_scale, cfg_step}), 32'h0);
      read_check(5'h04, 32'h0, "R1");
      read_check(5'h08, 32'h0, "R1");
      read_check(5'h0C, 32'h0, "R1");
      read_check(5'h10, 32'h0, "R1");
      @(negedge clk);
      bus_sel = 1'b0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule